// File: doc/BRIEF.md
# Triggered delayed pulse generator

This block produces one timed pulse per start event. A start event is either a one-cycle software strobe or a rising edge on an asynchronous trigger input. When an event is taken, an internal tick counter restarts from zero and advances once per prescaled tick. The pulse turns on when the counter reaches the delay compare value. It turns off when the counter reaches the end compare value, and the counter then halts.

The prescaler divides the clock by a power of two chosen by a 3-bit select. Two modes are available:

- **Single-shot:** the block ignores new events until the current pulse has finished. It raises a done flag when the pulse ends.
- **Retriggered:** every event clears the output and restarts the count, so a periodic trigger gives one narrow pulse per trigger period.

An output polarity bit selects whether the pulse is driven high or low.

Top module: `dly_pulse_gen`

## Requirements
- R1: While reset is asserted, the pulse pin sits at its inactive level and the done flag is 0.
- R2: The prescale select s (0..7) sets the tick divisor N = 2^s (1 to 128). Take E as the clock edge that accepts an event. The pulse is active at the sample taken after edge E+k exactly when dly_cmp*N <= k < end_cmp*N.
- R3: Once the count reaches end_cmp, the pulse goes inactive and the counter halts. No further pulse appears until another event is accepted.
- R4: In single-shot mode, done rises at the same edge that ends the pulse and stays set. It is cleared by the edge that accepts the next event.
- R5: In single-shot mode, a start strobe during the delay or the pulse is ignored. The waveform and the end time are unchanged.
- R6: The trigger passes through a two-flop synchroniser followed by rising-edge detection. An event is accepted at the third rising clock edge at which the trigger is high after having been low. In single-shot mode, a trigger edge starts a shot exactly as a strobe does.
- R7: In retriggered mode, every strobe or trigger edge is accepted, including one that arrives mid-pulse. Each accepted event forces the pulse inactive at that edge and restarts the count from zero. The done flag stays 0 in this mode.
- R8: With act_high = 1 the active level is 1, and with act_high = 0 it is 0. The polarity applies at once, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_sel | input | 3 | Prescale select, divisor 2^psc_sel |
| dly_cmp | input | 16 | Tick count at which the pulse turns on |
| end_cmp | input | 16 | Tick count at which the pulse turns off and counting halts |
| retrig_mode | input | 1 | 0 single-shot, 1 retriggered |
| act_high | input | 1 | 1 pulse active high, 0 active low |
| start | input | 1 | One-cycle software start strobe |
| trig_in | input | 1 | Asynchronous trigger input |
| pulse_o | output | 1 | Pulse output |
| done_o | output | 1 | Single-shot completion flag |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 3-bit prescale select that reaches every divisor from 1 to 128, and a two-stage synchroniser. Small compare values keep each shot short enough that all eight divisors can be swept against several delay/width pairs and both polarities. Every cycle of every shot is compared with the arithmetic window dly_cmp*N..end_cmp*N. The directed cases cover the following:
- strobes injected mid-shot;
- trigger-edge latency;
- mid-pulse restarts in retriggered mode.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_RETRIG = 1'b1
  } shot_mode_e;

  typedef struct packed {
    logic run;
    logic active;
    logic done;
  } core_flags_t;
endpackage

// File: rtl/dpg_prescaler.sv
module dpg_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int MAX_SHIFT = (1 << SEL_W) - 1;
  localparam int PC_W      = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

  logic [PC_W-1:0] psc_q, psc_d, last_val;

  // terminal value 2^sel - 1 built as a thermometer mask
  always_comb begin
    for (int i = 0; i < PC_W; i++) begin
      last_val[i] = (i < int'(sel_i));
    end
  end

  assign tick_o = en_i && (psc_q >= last_val);

  always_comb begin
    psc_d = psc_q;
    if (clr_i)       psc_d = '0;
    else if (en_i)   psc_d = tick_o ? '0 : psc_q + PC_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  // R2: with a divisor above one, two ticks are never adjacent
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && sel_i != '0 && !clr_i) |=> (!tick_o || !$stable(sel_i)));
endmodule

// File: rtl/dpg_trig_sync.sv
module dpg_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q, sh_d;

  assign sh_d   = {sh_q[STAGES-1:0], trig_i};
  assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // R6: one detected edge per rising transition
  p_edge_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/dpg_core.sv
module dpg_core
  import dpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             trig_evt_i,
  input  logic             retrig_i,
  input  logic [CNT_W-1:0] dly_cmp_i,
  input  logic [CNT_W-1:0] end_cmp_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             active_o,
  output logic             done_o,
  output logic             accept_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  shot_mode_e       mode;
  core_flags_t      fl_q, fl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             evt, accept, step, hit_dly, hit_end, cnt_en;

  assign mode    = shot_mode_e'(retrig_i);
  assign evt     = start_i | trig_evt_i;
  assign accept  = evt && (mode == MODE_RETRIG || !fl_q.run);
  assign step    = fl_q.run && tick_i;
  assign cnt_inc = cnt_q + CNT_ONE;
  assign hit_dly = step && (cnt_inc == dly_cmp_i);
  assign hit_end = step && (cnt_inc == end_cmp_i);
  assign cnt_en  = accept || step;

  always_comb begin
    fl_d  = fl_q;
    cnt_d = cnt_q;
    if (accept) begin
      fl_d  = '{run: 1'b1, active: 1'b0, done: 1'b0};
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_inc;
      if (hit_end) begin
        fl_d.run    = 1'b0;
        fl_d.active = 1'b0;
        fl_d.done   = (mode == MODE_SINGLE);
      end else if (hit_dly) begin
        fl_d.active = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  assign run_o    = fl_q.run;
  assign active_o = fl_q.active;
  assign done_o   = fl_q.done;
  assign accept_o = accept;

  // R2: every run begins from a zero count
  p_start_from_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_q.run) |-> cnt_q == '0);
  // R2: without a tick the count holds
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_q.run && !tick_i && !accept) |=> $stable(cnt_q));
  // R4: completion only while idle with the pulse off
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_q.done |-> (!fl_q.run && !fl_q.active));
  // R5: single-shot run is not restarted by events
  p_shot_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_q.run && !retrig_i && !hit_end) |=> (fl_q.run && cnt_q >= $past(cnt_q)));
  // R7: an accepted retrigger clears the pulse
  p_retrig_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retrig_i && evt) |=> !fl_q.active);
endmodule

// File: rtl/dly_pulse_gen.sv
module dly_pulse_gen #(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 3,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] psc_sel,
  input  logic [CNT_W-1:0] dly_cmp,
  input  logic [CNT_W-1:0] end_cmp,
  input  logic             retrig_mode,
  input  logic             act_high,
  input  logic             start,
  input  logic             trig_in,
  output logic             pulse_o,
  output logic             done_o
);
  logic trig_evt, tick, run, active, accept;

  dpg_trig_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_in),
    .edge_o (trig_evt)
  );

  dpg_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept),
    .en_i   (run),
    .sel_i  (psc_sel),
    .tick_o (tick)
  );

  dpg_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .trig_evt_i (trig_evt),
    .retrig_i   (retrig_mode),
    .dly_cmp_i  (dly_cmp),
    .end_cmp_i  (end_cmp),
    .tick_i     (tick),
    .run_o      (run),
    .active_o   (active),
    .done_o     (done_o),
    .accept_o   (accept)
  );

  // R8: polarity applied after the state register
  assign pulse_o = act_high ? active : ~active;
endmodule

// File: tb/sim_dly_pulse_gen.sv
`timescale 1ns/1ps
module sim_dly_pulse_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  psc_sel;
  logic [15:0] dly_cmp, end_cmp;
  logic        retrig_mode, act_high, start, trig_in;
  logic        pulse_o, done_o;
  int          n_tests = 0;
  int          n_fail  = 0;

  always #4 clk = ~clk;

  dly_pulse_gen u0 (
    .clk(clk), .rst_n(rst_n), .psc_sel(psc_sel), .dly_cmp(dly_cmp),
    .end_cmp(end_cmp), .retrig_mode(retrig_mode), .act_high(act_high),
    .start(start), .trig_in(trig_in), .pulse_o(pulse_o), .done_o(done_o)
  );

  task automatic check1(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic launch_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic launch_trig();
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    trig_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // compares every sample k = 0..kmax after the accepting edge
  task automatic observe(input string tag, input int n_div, input int d,
                         input int e, input logic act, input logic rt,
                         input int kmax, input int inj_k);
    int   bad_k = -1;
    logic bp = 1'b0, bd = 1'b0, ep_b = 1'b0, ed_b = 1'b0;
    for (int k = 0; k <= kmax; k++) begin
      logic on, ep, ed;
      if (k > 0) @(negedge clk);
      on = (k >= d * n_div) && (k < e * n_div);
      ep = act ? on : ~on;
      ed = !rt && (k >= e * n_div);
      if (bad_k < 0 && (pulse_o !== ep || done_o !== ed)) begin
        bad_k = k; bp = pulse_o; bd = done_o; ep_b = ep; ed_b = ed;
      end
      start = (k == inj_k);
    end
    start = 1'b0;
    n_tests++;
    if (bad_k >= 0) begin
      n_fail++;
      $display("FAIL %s N=%0d d=%0d e=%0d k=%0d pulse actual=%b expected=%b done actual=%b expected=%b",
               tag, n_div, d, e, bad_k, bp, ep_b, bd, ed_b);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int dl[3] = '{2, 5, 3};
    int wd[3] = '{1, 3, 2};
    rst_n = 1'b0; psc_sel = '0; dly_cmp = 16'd2; end_cmp = 16'd3;
    retrig_mode = 1'b0; act_high = 1'b1; start = 1'b0; trig_in = 1'b0;
    repeat (3) @(negedge clk);
    check1("R1 pulse in reset", pulse_o, 1'b0);
    check1("R1 done in reset", done_o, 1'b0);
    act_high = 1'b0;
    #1;
    check1("R8 active-low idle level in reset", pulse_o, 1'b1);
    act_high = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R8: sweep of all divisors, delay/width pairs, polarities
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 3; p++) begin
        for (int a = 0; a < 2; a++) begin
          psc_sel  = 3'(s);
          dly_cmp  = 16'(dl[p]);
          end_cmp  = 16'(dl[p] + wd[p]);
          act_high = a[0];
          launch_start();
          observe("R2 R3 R4 R8 sweep", 1 << s, dl[p], dl[p] + wd[p], a[0], 1'b0,
                  (dl[p] + wd[p]) * (1 << s) + 3 * (1 << s) + 4, -1);
        end
      end
    end

    // R4: done still set, then cleared by the next start
    check1("R4 done held after shot", done_o, 1'b1);
    psc_sel = 3'd0; dly_cmp = 16'd4; end_cmp = 16'd6; act_high = 1'b1;
    launch_start();
    check1("R4 done cleared by new start", done_o, 1'b0);
    observe("R4 shot after done", 1, 4, 6, 1'b1, 1'b0, 10, -1);

    // R5: start strobes mid-pulse and mid-delay are ignored
    dly_cmp = 16'd4; end_cmp = 16'd8;
    launch_start();
    observe("R5 strobe during pulse", 1, 4, 8, 1'b1, 1'b0, 14, 5);
    psc_sel = 3'd2;
    launch_start();
    observe("R5 strobe during delay", 4, 4, 8, 1'b1, 1'b0, 40, 6);

    // R6: trigger edge starts a single shot after the synchroniser
    psc_sel = 3'd1; dly_cmp = 16'd2; end_cmp = 16'd5;
    launch_trig();
    observe("R6 trigger start", 2, 2, 5, 1'b1, 1'b0, 16, -1);
    check1("R6 held-high trigger gives no new shot", pulse_o, 1'b0);

    // R7: retriggered mode
    retrig_mode = 1'b1; psc_sel = 3'd0; dly_cmp = 16'd3; end_cmp = 16'd8;
    launch_trig();
    observe("R7 retrig first", 1, 3, 8, 1'b1, 1'b1, 4, -1);
    launch_start();
    observe("R7 restart by strobe mid-pulse", 1, 3, 8, 1'b1, 1'b1, 12, -1);
    launch_trig();
    observe("R7 trigger arm", 1, 3, 8, 1'b1, 1'b1, 1, -1);
    launch_trig();
    observe("R7 restart by trigger mid-pulse", 1, 3, 8, 1'b1, 1'b1, 12, -1);
    psc_sel = 3'd3; act_high = 1'b0;
    launch_start();
    observe("R7 R8 retrig prescaled active-low", 8, 3, 8, 1'b0, 1'b1, 70, -1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule